// File: doc/BRIEF.md
# Word-Framed Two-Wire Bus Slave

This block is the serial front end of a command-driven peripheral. It watches an I2C-compatible two-wire bus through an oversampling system clock and finds start, repeated-start and stop conditions. It answers one 7-bit address, whose upper five bits are fixed at 01011 and whose lowest two bits come from a pair of strap inputs. Write traffic is gathered two bytes at a time into 16-bit command words, most significant byte first. Each complete word is handed to the core on a one-cycle strobe. Read traffic returns a 16-bit word captured from the core, again most significant byte first.

The block drives SDA only as an open-drain output. The enable `sda_oe` pulls the line low, and the block changes it only while SCL is low. While the core reports a nonvolatile program in progress on `busy`, the slave refuses to acknowledge its own address. The master can therefore poll with start, address and write bit until an acknowledge comes back. After one address phase, a writing master may send any number of byte pairs back to back. A stop or a new start that falls in the middle of a pair throws the half word away.

Top module: `i2cw_slave`

## Requirements
- R1: The address byte is acknowledged only when its upper seven bits equal {5'b01011, addr_lo}. Bit 0 of the address byte is the direction: 0 means write and 1 means read. Any other address receives no acknowledge and delivers no command word.
- R2: For an accepted write, the slave pulls SDA low during the ninth SCL clock of the address byte and of every data byte.
- R3: Two data bytes after a write address form cmd_word = {first byte, second byte}, each byte sent MSB first. cmd_valid is high for exactly one system clock, after the falling SCL edge that ends the second byte's acknowledge clock.
- R4: Further byte pairs in the same address phase each produce their own cmd_word and cmd_valid pulse, in the order they were sent.
- R5: A stop after an odd number of data bytes delivers no word for the last byte. The next transfer starts a fresh pair.
- R6: On an accepted read, rd_data is captured during the address acknowledge. The captured word is sent MSB first as a high byte and then a low byte. A later change of rd_data does not alter the bytes being sent.
- R7: If the master does not acknowledge the first read byte, the slave leaves SDA released through the following eight clocks, so the master reads 8'hFF.
- R8: While busy is high at the eighth address bit, the address is not acknowledged and no word is delivered. Once busy is low, the same address is acknowledged again.
- R9: sda_oe changes only while SCL is low.
- R10: A repeated start aborts the current transfer, discards any half word and begins a new address phase.
- R11: After reset, sda_oe and cmd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| addr_lo | input | 2 | Two low address bits from the strap |
| busy | input | 1 | Nonvolatile program in progress; address is not acknowledged |
| rd_data | input | 16 | Word returned on reads |
| cmd_valid | output | 1 | One-cycle strobe for a received command word |
| cmd_word | output | 16 | Received command word, first byte in the upper half |

## Verification
The embedded properties assume that SCL stays low for at least two system clocks after each falling edge, and that the master never makes a start or stop while the slave holds SDA low. The bench master holds every SCL phase for tens of system clocks. It moves SDA only in the middle of the low phase, and it issues a stop or start only after the slave has released the line following an acknowledge or a NACK. Random transfers draw the strap value, address corruption, busy, direction, pair count, an odd trailing byte and the master's acknowledge. They keep within these bus rules.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    // Fixed upper part of the slave address.
    localparam logic [4:0] ADDR_HI_BITS = 5'b01011;

    // Transfer phase of the protocol engine.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WR   = 2'd2,
        ST_RD   = 2'd3
    } eng_state_t;
endpackage

// File: rtl/i2cw_sync.sv
// Multi-stage synchronizer for asynchronous bus pins.
// Assumes the lines idle high, so the reset value is 1 to avoid false edges.
module i2cw_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Register one synchronizer stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe[s] <= '1;
                end else begin
                    if (s == 0) pipe[s] <= d;
                    else        pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cw_cond.sv
// Bus condition detector: SCL edges and start/stop conditions.
// Assumes synchronized inputs. Start and stop need SCL high in both samples.
module i2cw_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic scl_q, sda_q;

    // Hold the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cw_engine.sv
// Protocol engine: address match, write word assembly, read serialization.
// Assumes one-cycle strobes from i2cw_cond and SCL low for at least two
// system clocks after each falling edge.
module i2cw_engine
    import i2cw_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_s,
    input  logic                sda_s,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_p,
    input  logic                stop_p,
    input  logic [1:0]          addr_lo,
    input  logic                busy,
    input  logic [2*BYTE_W-1:0] rd_data,
    output logic                sda_oe,
    output logic                cmd_valid,
    output logic [2*BYTE_W-1:0] cmd_word
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] END_CNT  = CNT_W'(BYTE_W + 1);
    localparam logic [ADDR_W-1:0] MY_ADDR_BASE = ADDR_W'({ADDR_HI_BITS, 2'b00});

    eng_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx;
    logic [BYTE_W-1:0] hi_byte;
    logic              hi_done;
    logic              hit;
    logic              rd_mode;
    logic              mack;
    logic              second;
    logic [WORD_W-1:0] tx;
    logic [ADDR_W-1:0] my_addr;

    assign my_addr = MY_ADDR_BASE | ADDR_W'(addr_lo);

    // Main bus sequencer: steps on SCL edges, restarts on start/stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            rx        <= '0;
            hi_byte   <= '0;
            hi_done   <= 1'b0;
            hit       <= 1'b0;
            rd_mode   <= 1'b0;
            mack      <= 1'b0;
            second    <= 1'b0;
            tx        <= '0;
            sda_oe    <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_word  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (start_p) begin
                state   <= ST_ADDR;
                cnt     <= '0;
                sda_oe  <= 1'b0;
                hi_done <= 1'b0;
            end else if (stop_p) begin
                state   <= ST_IDLE;
                cnt     <= '0;
                sda_oe  <= 1'b0;
                hi_done <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    if (cnt < ACK_CNT) begin
                        cnt <= cnt + 1'b1;
                        if (state != ST_RD) rx <= {rx[BYTE_W-2:0], sda_s};
                        if (state == ST_ADDR && cnt == LAST_BIT) begin
                            hit     <= (rx[ADDR_W-1:0] == my_addr) && !busy;
                            rd_mode <= sda_s;
                        end
                    end else if (cnt == ACK_CNT) begin
                        cnt <= END_CNT;
                        if (state == ST_RD) mack <= !sda_s;
                    end
                end else if (scl_fall) begin
                    if (cnt == ACK_CNT) begin
                        case (state)
                            ST_ADDR: begin
                                sda_oe <= hit;
                                if (hit && rd_mode) tx <= rd_data;
                            end
                            ST_WR:   sda_oe <= 1'b1;
                            default: begin
                                sda_oe <= 1'b0;
                                tx     <= {tx[WORD_W-2:0], 1'b0};
                            end
                        endcase
                    end else if (cnt == END_CNT) begin
                        cnt <= '0;
                        case (state)
                            ST_ADDR: begin
                                if (!hit) begin
                                    state  <= ST_IDLE;
                                    sda_oe <= 1'b0;
                                end else if (rd_mode) begin
                                    state  <= ST_RD;
                                    second <= 1'b0;
                                    sda_oe <= !tx[WORD_W-1];
                                end else begin
                                    state  <= ST_WR;
                                    sda_oe <= 1'b0;
                                end
                            end
                            ST_WR: begin
                                sda_oe <= 1'b0;
                                if (hi_done) begin
                                    cmd_word  <= {hi_byte, rx};
                                    cmd_valid <= 1'b1;
                                    hi_done   <= 1'b0;
                                end else begin
                                    hi_byte <= rx;
                                    hi_done <= 1'b1;
                                end
                            end
                            default: begin
                                if (mack && !second) begin
                                    second <= 1'b1;
                                    sda_oe <= !tx[WORD_W-1];
                                end else begin
                                    state  <= ST_IDLE;
                                    sda_oe <= 1'b0;
                                end
                            end
                        endcase
                    end else if (state == ST_RD && cnt != '0) begin
                        tx     <= {tx[WORD_W-2:0], 1'b0};
                        sda_oe <= !tx[WORD_W-2];
                    end
                end
            end
        end
    end

    // R9
    sda_only_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R3
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R3
    cmd_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(state) == ST_WR);

    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= END_CNT);
endmodule

// File: rtl/i2cw_slave.sv
// Top of the word-framed bus slave: synchronizer, condition detector and
// protocol engine. Assumes clk runs well above the SCL rate.
module i2cw_slave #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    input  logic [1:0]          addr_lo,
    input  logic                busy,
    input  logic [2*BYTE_W-1:0] rd_data,
    output logic                cmd_valid,
    output logic [2*BYTE_W-1:0] cmd_word
);
    logic [1:0] pins_s;
    logic       scl_rise, scl_fall, start_p, stop_p;

    i2cw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (pins_s)
    );

    i2cw_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (pins_s[1]),
        .sda_s    (pins_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    i2cw_engine #(.BYTE_W(BYTE_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (pins_s[1]),
        .sda_s     (pins_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .addr_lo   (addr_lo),
        .busy      (busy),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word)
    );
endmodule

// File: tb/tb_i2cw_slave.sv
module tb_i2cw_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_lo = 2'b11;
    logic        busy = 1'b0;
    logic [15:0] rd_data = 16'h0000;
    logic        sda_oe, cmd_valid;
    logic [15:0] cmd_word;
    wire         sda_bus = sda_m & ~sda_oe;

    int checks = 0, bad = 0, cap_n = 0, hi_chg = 0;
    logic [15:0] cap_w [0:255];
    logic oe_prev = 1'b0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    i2cw_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_lo(addr_lo), .busy(busy), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word)
    );

    // Capture every delivered command word.
    always @(posedge clk) if (rst_n && cmd_valid) begin
        cap_w[cap_n[7:0]] <= cmd_word;
        cap_n <= cap_n + 1;
    end

    // Count SDA enable changes seen while SCL is high (R9).
    always @(negedge clk) begin
        if (rst_n && sda_oe != oe_prev && scl) hi_chg++;
        oe_prev = sda_oe;
    end

    function automatic bit addr_hit(input logic [6:0] a7, input logic [1:0] lo, input logic bsy);
        return (a7 == {5'b01011, lo}) && !bsy;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(); repeat (10) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(); scl = 1'b1; hold(); sda_m = 1'b0; hold(); scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(); scl = 1'b1; hold(); sda_m = 1'b1; hold(); hold();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(); scl = 1'b1; hold(); hold(); scl = 1'b0; hold();
        end
        sda_m = 1'b1; hold(); scl = 1'b1; hold(); acked = !sda_bus; hold(); scl = 1'b0; hold();
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(); scl = 1'b1; hold(); b[i] = sda_bus; hold(); scl = 1'b0;
        end
        sda_m = !give_ack; hold(); scl = 1'b1; hold(); hold(); scl = 1'b0; hold();
        sda_m = 1'b1;
    endtask

    // Write transfer: address, then nbytes of data; checks every ACK.
    task automatic wr_xfer(input logic [6:0] a7, input int nbytes,
                           input logic [15:0] w [0:3], input bit do_stop);
        logic ak;
        bit   exp_hit;
        exp_hit = addr_hit(a7, addr_lo, busy);
        bus_start();
        put_byte({a7, 1'b0}, ak);
        check(exp_hit ? "R2 addr ack" : "R1/R8 addr nack", ak, exp_hit);
        if (exp_hit) begin
            for (int k = 0; k < nbytes; k++) begin
                put_byte(k[0] ? w[k/2][7:0] : w[k/2][15:8], ak);
                check("R2 data ack", ak, 1);
            end
        end
        if (do_stop) bus_stop();
    endtask

    // Check the words captured since base against the expected list.
    task automatic check_words(input string tag, input int base, input int n,
                               input logic [15:0] w [0:3]);
        check({tag, " count"}, cap_n - base, n);
        for (int k = 0; k < n && k < cap_n - base; k++)
            check({tag, " word"}, cap_w[(base + k) % 256], w[k]);
    endtask

    // Read transfer: returns both bytes; first_ack is the master ACK on byte 1.
    task automatic rd_xfer(input logic [6:0] a7, input logic first_ack,
                           output logic ak, output logic [15:0] got);
        logic [7:0] b1, b2;
        bus_start();
        put_byte({a7, 1'b1}, ak);
        get_byte(first_ack, b1);
        get_byte(1'b0, b2);
        bus_stop();
        got = {b1, b2};
    endtask

    initial begin
        logic [15:0] w [0:3];
        logic [15:0] got;
        logic ak;
        int base;
        int unsigned seed_init;
        seed_init = $urandom(32'h1234_5678);

        repeat (5) @(negedge clk);
        check("R11 oe after reset", sda_oe, 0);
        check("R11 valid after reset", cmd_valid, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3: single pair
        w = '{16'h1234, 16'h0, 16'h0, 16'h0};
        base = cap_n;
        wr_xfer(7'h2F, 2, w, 1);
        check_words("R3 pair", base, 1, w);

        // R4: three pairs in one address phase
        w = '{16'hA55A, 16'h0FF0, 16'hC381, 16'h0};
        base = cap_n;
        wr_xfer(7'h2F, 6, w, 1);
        check_words("R4 multi", base, 3, w);

        // R5: odd trailing byte discarded, next pair fresh
        w = '{16'h1357, 16'h9B00, 16'h0, 16'h0};
        base = cap_n;
        wr_xfer(7'h2F, 3, w, 1);
        check_words("R5 odd", base, 1, w);
        w = '{16'h2468, 16'h0, 16'h0, 16'h0};
        base = cap_n;
        wr_xfer(7'h2F, 2, w, 1);
        check_words("R5 fresh", base, 1, w);

        // R1: wrong address, then other strap value
        base = cap_n;
        wr_xfer(7'h2E, 2, w, 1);
        check("R1 wrong addr no word", cap_n - base, 0);
        addr_lo = 2'b00;
        w = '{16'h0102, 16'h0, 16'h0, 16'h0};
        base = cap_n;
        wr_xfer(7'h2C, 2, w, 1);
        check_words("R1 strap 00", base, 1, w);
        addr_lo = 2'b10;

        // R8: busy refuses, then polling succeeds
        busy = 1'b1;
        base = cap_n;
        wr_xfer(7'h2E, 2, w, 1);
        check("R8 busy no word", cap_n - base, 0);
        busy = 1'b0;
        w = '{16'hBEEF, 16'h0, 16'h0, 16'h0};
        base = cap_n;
        wr_xfer(7'h2E, 2, w, 1);
        check_words("R8 after busy", base, 1, w);

        // R6: read with latch check (rd_data changes after address)
        rd_data = 16'hA5C3;
        bus_start();
        put_byte({7'h2E, 1'b1}, ak);
        check("R6 read addr ack", ak, 1);
        rd_data = 16'h0000;
        begin
            logic [7:0] b1, b2;
            get_byte(1'b1, b1);
            get_byte(1'b0, b2);
            bus_stop();
            check("R6 read word latched", {b1, b2}, 16'hA5C3);
        end

        // R7: master NACK on first byte
        rd_data = 16'h3C00;
        rd_xfer(7'h2E, 1'b0, ak, got);
        check("R7 first byte", got[15:8], 8'h3C);
        check("R7 second released", got[7:0], 8'hFF);

        // R10: repeated start discards half word, then read works
        base = cap_n;
        w = '{16'h7700, 16'h0, 16'h0, 16'h0};
        wr_xfer(7'h2E, 1, w, 0);
        rd_data = 16'h5AA5;
        rd_xfer(7'h2E, 1'b1, ak, got);
        check("R10 read after rstart", got, 16'h5AA5);
        check("R10 half word dropped", cap_n - base, 0);
        w = '{16'h6611, 16'h0, 16'h0, 16'h0};
        wr_xfer(7'h2E, 1, w, 0);
        w = '{16'h4321, 16'h0, 16'h0, 16'h0};
        base = cap_n;
        wr_xfer(7'h2E, 2, w, 1);
        check_words("R10 rstart write", base, 1, w);

        // Random traffic
        for (int t = 0; t < 24; t++) begin
            logic [1:0] lo;
            logic [6:0] a7;
            bit rd, hit;
            int np, extra;
            case ($urandom % 3)
                0: lo = 2'b11;
                1: lo = 2'b00;
                default: lo = 2'b10;
            endcase
            addr_lo = lo;
            a7 = {5'b01011, lo};
            if ($urandom % 4 == 0) a7 = a7 ^ 7'(($urandom % 127) + 1);
            busy = ($urandom % 5 == 0);
            rd = $urandom % 2;
            hit = addr_hit(a7, lo, busy);
            if (rd) begin
                logic fa;
                logic [15:0] exp_w;
                rd_data = 16'($urandom);
                fa = $urandom % 2;
                rd_xfer(a7, fa, ak, got);
                check("R1 rand read addr", ak, hit);
                exp_w = hit ? (fa ? rd_data : {rd_data[15:8], 8'hFF}) : 16'hFFFF;
                check(fa ? "R6 rand read" : "R7 rand read", got, exp_w);
            end else begin
                np = 1 + $urandom % 3;
                extra = $urandom % 2;
                for (int k = 0; k < 4; k++) w[k] = 16'($urandom);
                base = cap_n;
                wr_xfer(a7, 2 * np + extra, w, 1);
                check_words(hit ? "R4 rand write" : "R8 rand refuse", base, hit ? np : 0, w);
            end
        end
        busy = 1'b0;

        check("R9 oe changes while SCL high", hi_chg, 0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule